// File: doc/BRIEF.md
# Expansion Adapter Option Registers

This block is the configuration register file of a memory expansion adapter. It sits on a byte-wide register window of eight offsets, with read and write strobes, a 3-bit offset, and 8-bit data in each direction. Two offsets return fixed identification bytes. One register holds the window-enable bit. That bit drives an output which gates the adapter's memory range in the address decoder.

A 1024-byte indirect array is reached through one data-port offset. Two pointer registers select the location, and only the low 10 bits of their 16-bit concatenation take part. The block also presents the decoded window base, the window length and the length of the planar region below it. These three values come from a start-megabyte parameter and a total-megabyte parameter. The reset value of the size-code register follows from the same two parameters.

Every read completes one clock after its strobe, with a valid flag beside the data.

Top module: `optreg_file`

## Requirements
- R1: Offsets 0 and 1 both read 0xFE; writes to them change nothing that a later read of any offset returns.
- R2: A write to offset 2 loads only bit 0 from the data; bits 7:1 keep their value.
- R3: A write to offset 5 stores data bits 7:1 into bits 7:1, and stores the current offset 2 bit 0 into bit 0.
- R4: Writes to offsets 4, 6 and 7 store the full byte, which a later read of that offset returns.
- R5: A write to offset 3 stores the byte into the array at pointer P = {offset 7, offset 6}[9:0]. Pointer bits 15:10 are ignored, so pointers that differ only there reach the same location.
- R6: A read of offset 3 returns the array byte at P. The byte is held as the offset 3 register, and a write to offset 3 does not change that register.
- R7: The pointer is not changed by data-port reads or writes.
- R8: Output win_en equals offset 2 bit 0. It changes on the clock edge that takes the write, and it is 0 from reset.
- R9: rvalid is high exactly in the cycle after a cycle with rd_en high, and rdata carries the result in that cycle.
- R10: win_base = START_MB·2^20, win_len = (TOTAL_MB−START_MB)·2^20, planar_len = (START_MB−1)·2^20.
- R11: Reset values are as follows. Offset 2 is 0xFE, 0xFA or 0xAA when TOTAL_MB−START_MB is 0, 1 or 2. Offset 5 is 0xFE. Offsets 4, 6 and 7 are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | Read result valid |
| win_en | output | 1 | Memory window enable |
| win_base | output | 32 | Window base address |
| win_len | output | 32 | Window length in bytes |
| planar_len | output | 32 | Planar region length above 1 MB |

## Verification
A corrupted bit in offset 2 shows on win_en in the very next cycle. The same fault also shows in the low bit of offset 5 after the next write there. A wrong pointer or a wrong array slice stays hidden until a data-port read. That read then returns a byte other than the one written, one clock after the strobe. The aliasing tests therefore write through one pointer and read through another that differs only in bits 15:10.

// File: rtl/optreg_file.sv
module optreg_file #(
  parameter int DEPTH    = 1024,
  parameter int START_MB = 2,
  parameter int TOTAL_MB = 4,
  parameter logic [7:0] ID_BYTE = 8'hFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rvalid,
  output logic        win_en,
  output logic [31:0] win_base,
  output logic [31:0] win_len,
  output logic [31:0] planar_len
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int HI_W  = PTR_W - 8;
  localparam int EXTRA = TOTAL_MB - START_MB;
  localparam logic [7:0] SIZE_RST = (EXTRA == 0) ? 8'hFE :
                                    (EXTRA == 1) ? 8'hFA : 8'hAA;

  logic [7:0] size_q, data_q, aux_q, misc_q, ptr_lo, ptr_hi;
  logic [7:0] arr [DEPTH];
  logic [7:0] rd_hold, rd_mux;
  logic [2:0] rd_sel;
  logic       rd_pend;
  logic [PTR_W-1:0] ptr;

  assign ptr        = {ptr_hi[HI_W-1:0], ptr_lo};
  assign win_en     = size_q[0];
  assign win_base   = 32'(START_MB) << 20;
  assign win_len    = 32'(EXTRA) << 20;
  assign planar_len = 32'(START_MB - 1) << 20;
  assign rvalid     = rd_pend;
  assign rdata      = (rd_sel == 3'd3) ? data_q : rd_hold;

  always_comb begin
    case (addr)
      3'd0, 3'd1: rd_mux = ID_BYTE;
      3'd2:       rd_mux = size_q;
      3'd4:       rd_mux = misc_q;
      3'd5:       rd_mux = aux_q;
      3'd6:       rd_mux = ptr_lo;
      3'd7:       rd_mux = ptr_hi;
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_en && addr == 3'd3) arr[ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q  <= SIZE_RST;
      aux_q   <= 8'hFE;
      misc_q  <= 8'h00;
      ptr_lo  <= 8'h00;
      ptr_hi  <= 8'h00;
      data_q  <= 8'h00;
      rd_hold <= 8'h00;
      rd_sel  <= 3'd0;
      rd_pend <= 1'b0;
    end else begin
      rd_pend <= rd_en;
      if (rd_en) begin
        rd_sel  <= addr;
        rd_hold <= rd_mux;
        if (addr == 3'd3) data_q <= arr[ptr];
      end
      if (wr_en) begin
        case (addr)
          3'd2: size_q <= {size_q[7:1], wdata[0]};
          3'd4: misc_q <= wdata;
          3'd5: aux_q  <= {wdata[7:1], size_q[0]};
          3'd6: ptr_lo <= wdata;
          3'd7: ptr_hi <= wdata;
          default: ;
        endcase
      end
    end
  end

  a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> size_q[7:1] == $past(size_q[7:1]));

  a_r3_low_from_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5) |=> aux_q[0] == $past(win_en));

  a_r6_port_write_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && !rd_en) |=> $stable(data_q));

  a_r7_no_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && addr == 3'd3) |=> $stable(ptr));

  a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  a_r8_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd2) |=> $stable(win_en));
endmodule

// File: tb/optreg_file_test.sv
module optreg_file_test;
  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rvalid, win_en;
  logic [31:0] win_base, win_len, planar_len;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  optreg_file uut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .win_en(win_en),
    .win_base(win_base), .win_len(win_len), .planar_len(planar_len));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL R9 watchdog expired: actual hang expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    check("R9 rvalid", {31'd0, rvalid}, 32'd1);
    d = rdata;
    @(negedge clk);
    check("R9 rvalid drop", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R8 enable at reset", {31'd0, win_en}, 32'd0);
    check("R9 idle rvalid", {31'd0, rvalid}, 32'd0);
    rd(3'd2, v); check("R11 offset2 reset", {24'd0, v}, 32'hAA);
    rd(3'd5, v); check("R11 offset5 reset", {24'd0, v}, 32'hFE);
    rd(3'd4, v); check("R11 offset4 reset", {24'd0, v}, 32'h00);
    rd(3'd7, v); check("R11 offset7 reset", {24'd0, v}, 32'h00);
  endtask

  task automatic t_ids;
    logic [7:0] v;
    wr(3'd0, 8'h12); wr(3'd1, 8'h34);
    rd(3'd0, v); check("R1 id0", {24'd0, v}, 32'hFE);
    rd(3'd1, v); check("R1 id1", {24'd0, v}, 32'hFE);
    rd(3'd4, v); check("R1 write to id left offset4", {24'd0, v}, 32'h00);
    check("R1 write to id left enable", {31'd0, win_en}, 32'd0);
  endtask

  task automatic t_enable;
    logic [7:0] v;
    @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    check("R8 enable next cycle", {31'd0, win_en}, 32'd1);
    rd(3'd2, v); check("R2 only bit0", {24'd0, v}, 32'hAB);
    wr(3'd5, 8'h00);
    rd(3'd5, v); check("R3 bit0 from enable set", {24'd0, v}, 32'h01);
    wr(3'd2, 8'hFE);
    check("R8 enable cleared", {31'd0, win_en}, 32'd0);
    rd(3'd2, v); check("R2 upper kept on clear", {24'd0, v}, 32'hAA);
    wr(3'd5, 8'h33);
    rd(3'd5, v); check("R3 bit0 from enable clear", {24'd0, v}, 32'h32);
  endtask

  task automatic t_plain;
    logic [7:0] v;
    wr(3'd4, 8'h5A); rd(3'd4, v); check("R4 offset4", {24'd0, v}, 32'h5A);
    wr(3'd6, 8'hC7); rd(3'd6, v); check("R4 offset6", {24'd0, v}, 32'hC7);
    wr(3'd7, 8'hE1); rd(3'd7, v); check("R4 offset7", {24'd0, v}, 32'hE1);
  endtask

  task automatic t_array;
    logic [7:0] v;
    wr(3'd6, 8'h10); wr(3'd7, 8'h00); wr(3'd3, 8'hC3);
    wr(3'd7, 8'h03); wr(3'd3, 8'h77);
    wr(3'd6, 8'hFF); wr(3'd7, 8'h03); wr(3'd3, 8'h9D);
    wr(3'd6, 8'h10); wr(3'd7, 8'hFC);
    rd(3'd3, v); check("R5 alias high bits", {24'd0, v}, 32'hC3);
    wr(3'd7, 8'h07);
    rd(3'd3, v); check("R6 read at 0x310", {24'd0, v}, 32'h77);
    wr(3'd3, 8'h44);
    rd(3'd3, v); check("R6 overwrite same pointer", {24'd0, v}, 32'h44);
    rd(3'd6, v); check("R7 low pointer kept", {24'd0, v}, 32'h10);
    rd(3'd7, v); check("R7 high pointer kept", {24'd0, v}, 32'h07);
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd3, v); check("R5 top location", {24'd0, v}, 32'h9D);
  endtask

  task automatic t_decode;
    check("R10 base", win_base, 32'h0020_0000);
    check("R10 length", win_len, 32'h0020_0000);
    check("R10 planar", planar_len, 32'h0010_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_enable();
    t_plain();
    t_array();
    t_decode();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule